// File: doc/BRIEF.md
# Correlated Double Sampling Sequencer

This block times one pixel front-end through a full correlated double sampling cycle. A single start pulse launches the cycle. The block first holds the integrator in reset and lets it settle. It then arms the discriminator by holding it in reset while a threshold charge is injected. The discriminator is released on the same edge that takes the first (pedestal) sample. After that the block injects a test charge and waits for the integrator to settle again. It takes the second sample only after that wait. Last, it raises the readout multiplexer select so that the pair of samples can be read as a differential value.

The block also watches the discriminator output while the injected charge is being integrated. It turns the first firing in that window into a digital hit pulse, delayed by a programmable number of cycles. It holds two configuration fields for the analog path: an input polarity bit and a 3-bit input-capacitance code. Both can only change while no cycle is running. The analog integrator, comparator and sample capacitors are outside the block. Every phase length is a cycle-count parameter.

Top module: `cds_sequencer`

## Requirements
- R1: After reset, every strobe output, `busy` and `hitOut` are low, `polarityInvert` is 0 (non-inverting path) and `capSel` is 3'b111.
- R2: Counting the clock edge that samples `start` as edge 0, the strobe pins change one edge later. The pins then run in this fixed order: `intReset` for INTRST_CYC cycles, a first settle for the effective first-settle length, `thresholdInject` for THRESH_CYC cycles, one `sample1` cycle, `chargeInject` for INJECT_CYC plus SETTLE2_CYC cycles, one `sample2` cycle, and `muxSelect` for READ_CYC cycles. `discReset` is high from the first `intReset` cycle through the last `thresholdInject` cycle.
- R3: `sample1` is high for exactly one cycle. That cycle is the first one in which `discReset` is low again.
- R4: `sample2` is high for exactly one cycle. That cycle directly follows the last `chargeInject` cycle, so it comes only after the full second settling interval.
- R5: The effective first-settle length is SETTLE1_CYC when SETTLE1_CYC > SETTLE2_CYC, and SETTLE2_CYC+1 otherwise. The first settle is therefore always longer than the second.
- R6: A hit is accepted when `hitIn` is high at an edge where `chargeInject` is high. Only the first accepted hit of a cycle counts. It produces a one-cycle `hitOut` pulse exactly HIT_DELAY_CYC edges after the accepting edge, even when that lands after `busy` falls.
- R7: `hitIn` at any edge where `chargeInject` is low has no effect on `hitOut`. This includes the `sample1` and `sample2` cycles and idle time.
- R8: `cfgWrite` loads `cfgPolarity` and `cfgCapSel` at an edge where `busy` is low. At an edge where `busy` is high, it is ignored.
- R9: `capWeight` gives the added input capacitance in units: 7 minus `capSel`. Code 3'b111 gives 0 (none added) and code 3'b000 gives 7 (maximum).
- R10: `start` at an edge while a cycle is running is ignored. The running sequence is not altered.
- R11: `busy` is high from the first `intReset` cycle through the last `muxSelect` cycle, and low otherwise. While `busy` is low, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one sampling cycle when idle |
| hitIn | input | 1 | Discriminator output level |
| cfgWrite | input | 1 | Loads the configuration fields |
| cfgPolarity | input | 1 | New polarity: 1 selects the inverting path |
| cfgCapSel | input | 3 | New input-capacitance code |
| intReset | output | 1 | Integrator reset |
| discReset | output | 1 | Discriminator reset |
| thresholdInject | output | 1 | Threshold charge injection |
| chargeInject | output | 1 | Test-charge injection; also marks the hit window |
| sample1 | output | 1 | First (pedestal) sample strobe |
| sample2 | output | 1 | Second (signal) sample strobe |
| muxSelect | output | 1 | Readout multiplexer select for the differential pair |
| busy | output | 1 | A cycle is running |
| hitOut | output | 1 | Delayed one-cycle digital hit pulse |
| polarityInvert | output | 1 | Current polarity selection |
| capSel | output | 3 | Current input-capacitance code |
| capWeight | output | 3 | Added capacitance units (7 minus code) |

## Verification
The bench builds the main instance with phase lengths 3, 5, 2, 3, 4 and 3 and a hit delay of 4. This gives a 22-cycle busy window in which every phase boundary can be named by slot number. A hit on the last window slot then places `hitOut` one cycle after `busy` falls, which shows the delay outliving the cycle. A second instance is built with a first settle of 2 against a second settle of 4. That makes the clamp stretch the first settle to 5, so its pin trace must match the main instance cycle for cycle.

// File: rtl/cds_seq_pkg.sv
package cds_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_INTRST,
    PH_SETTLE1,
    PH_THRESH,
    PH_SAMPLE1,
    PH_INJECT,
    PH_SETTLE2,
    PH_SAMPLE2,
    PH_READ
  } phase_e;

  // Strobes from the sequencing control to the pin datapath
  typedef struct packed {
    logic intReset;
    logic discReset;
    logic thresholdInject;
    logic chargeInject;
    logic sample1;
    logic sample2;
    logic muxSelect;
    logic busy;
    logic hitWindow;
    logic cycleStart;
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cds_seq_ctrl.sv
module cds_seq_ctrl
  import cds_seq_pkg::*;
#(
  parameter int INTRST_CYC  = 8,
  parameter int SETTLE1_CYC = 20,
  parameter int THRESH_CYC  = 4,
  parameter int INJECT_CYC  = 4,
  parameter int SETTLE2_CYC = 12,
  parameter int READ_CYC    = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobe
);

  // First settle is forced longer than the second
  localparam int SETTLE1_EFF = (SETTLE1_CYC > SETTLE2_CYC) ? SETTLE1_CYC : SETTLE2_CYC + 1;
  localparam int MAX_LEN = maxOf(maxOf(maxOf(INTRST_CYC, SETTLE1_EFF), maxOf(THRESH_CYC, INJECT_CYC)),
                                 maxOf(SETTLE2_CYC, READ_CYC));
  localparam int CW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  phase_e phase, nextPhase;
  logic [CW-1:0] remain;
  logic advance;

  function automatic logic [CW-1:0] lenMinusOne(input phase_e p);
    case (p)
      PH_INTRST:  return CW'(INTRST_CYC - 1);
      PH_SETTLE1: return CW'(SETTLE1_EFF - 1);
      PH_THRESH:  return CW'(THRESH_CYC - 1);
      PH_INJECT:  return CW'(INJECT_CYC - 1);
      PH_SETTLE2: return CW'(SETTLE2_CYC - 1);
      PH_READ:    return CW'(READ_CYC - 1);
      default:    return '0;
    endcase
  endfunction

  always_comb begin
    case (phase)
      PH_IDLE:    nextPhase = PH_INTRST;
      PH_INTRST:  nextPhase = PH_SETTLE1;
      PH_SETTLE1: nextPhase = PH_THRESH;
      PH_THRESH:  nextPhase = PH_SAMPLE1;
      PH_SAMPLE1: nextPhase = PH_INJECT;
      PH_INJECT:  nextPhase = PH_SETTLE2;
      PH_SETTLE2: nextPhase = PH_SAMPLE2;
      PH_SAMPLE2: nextPhase = PH_READ;
      default:    nextPhase = PH_IDLE;
    endcase
  end

  assign advance = (phase == PH_IDLE) ? start : (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else if (advance) begin
      phase  <= nextPhase;
      remain <= lenMinusOne(nextPhase);
    end else if (phase != PH_IDLE) begin
      remain <= remain - 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    strobe.busy       = (phase != PH_IDLE);
    strobe.cycleStart = (phase == PH_IDLE) && start;
    case (phase)
      PH_INTRST: begin
        strobe.intReset  = 1'b1;
        strobe.discReset = 1'b1;
      end
      PH_SETTLE1: strobe.discReset = 1'b1;
      PH_THRESH: begin
        strobe.discReset       = 1'b1;
        strobe.thresholdInject = 1'b1;
      end
      PH_SAMPLE1: strobe.sample1 = 1'b1;
      PH_INJECT, PH_SETTLE2: begin
        strobe.chargeInject = 1'b1;
        strobe.hitWindow    = 1'b1;
      end
      PH_SAMPLE2: strobe.sample2 = 1'b1;
      PH_READ:    strobe.muxSelect = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/cds_seq_datapath.sv
module cds_seq_datapath
  import cds_seq_pkg::*;
#(
  parameter int HIT_DELAY_CYC = 75,
  parameter int CAP_W         = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             hitIn,
  input  logic             cfgWrite,
  input  logic             cfgPolarity,
  input  logic [CAP_W-1:0] cfgCapSel,
  output logic             intReset,
  output logic             discReset,
  output logic             thresholdInject,
  output logic             chargeInject,
  output logic             sample1,
  output logic             sample2,
  output logic             muxSelect,
  output logic             busy,
  output logic             hitOut,
  output logic             polarityInvert,
  output logic [CAP_W-1:0] capSel,
  output logic [CAP_W-1:0] capWeight
);

  localparam int DW = (HIT_DELAY_CYC > 1) ? $clog2(HIT_DELAY_CYC) : 1;

  logic          windowQ;
  logic          hitTaken;
  logic          hitPending;
  logic [DW-1:0] delayLeft;
  logic          hitAccept;

  // Registered pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReset        <= 1'b0;
      discReset       <= 1'b0;
      thresholdInject <= 1'b0;
      chargeInject    <= 1'b0;
      sample1         <= 1'b0;
      sample2         <= 1'b0;
      muxSelect       <= 1'b0;
      busy            <= 1'b0;
      windowQ         <= 1'b0;
    end else begin
      intReset        <= strobe.intReset;
      discReset       <= strobe.discReset;
      thresholdInject <= strobe.thresholdInject;
      chargeInject    <= strobe.chargeInject;
      sample1         <= strobe.sample1;
      sample2         <= strobe.sample2;
      muxSelect       <= strobe.muxSelect;
      busy            <= strobe.busy;
      windowQ         <= strobe.hitWindow;
    end
  end

  // Hit capture in the window, first one only, then programmable delay
  assign hitAccept = windowQ && hitIn && !hitTaken;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitTaken   <= 1'b0;
      hitPending <= 1'b0;
      delayLeft  <= '0;
      hitOut     <= 1'b0;
    end else begin
      hitOut <= 1'b0;
      if (strobe.cycleStart) begin
        hitTaken <= 1'b0;
      end else if (hitAccept) begin
        hitTaken <= 1'b1;
      end
      if (hitAccept) begin
        hitPending <= 1'b1;
        delayLeft  <= DW'(HIT_DELAY_CYC - 1);
      end else if (hitPending) begin
        if (delayLeft == '0) begin
          hitOut     <= 1'b1;
          hitPending <= 1'b0;
        end else begin
          delayLeft <= delayLeft - 1'b1;
        end
      end
    end
  end

  // Configuration, writable only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polarityInvert <= 1'b0;
      capSel         <= '1;
    end else if (cfgWrite && !busy) begin
      polarityInvert <= cfgPolarity;
      capSel         <= cfgCapSel;
    end
  end

  assign capWeight = ~capSel;

endmodule

// File: rtl/cds_sequencer.sv
module cds_sequencer
  import cds_seq_pkg::*;
#(
  parameter int INTRST_CYC    = 8,
  parameter int SETTLE1_CYC   = 20,
  parameter int THRESH_CYC    = 4,
  parameter int INJECT_CYC    = 4,
  parameter int SETTLE2_CYC   = 12,
  parameter int READ_CYC      = 16,
  parameter int HIT_DELAY_CYC = 75
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       hitIn,
  input  logic       cfgWrite,
  input  logic       cfgPolarity,
  input  logic [2:0] cfgCapSel,
  output logic       intReset,
  output logic       discReset,
  output logic       thresholdInject,
  output logic       chargeInject,
  output logic       sample1,
  output logic       sample2,
  output logic       muxSelect,
  output logic       busy,
  output logic       hitOut,
  output logic       polarityInvert,
  output logic [2:0] capSel,
  output logic [2:0] capWeight
);

  strobe_t strobe;

  cds_seq_ctrl #(
    .INTRST_CYC (INTRST_CYC),
    .SETTLE1_CYC(SETTLE1_CYC),
    .THRESH_CYC (THRESH_CYC),
    .INJECT_CYC (INJECT_CYC),
    .SETTLE2_CYC(SETTLE2_CYC),
    .READ_CYC   (READ_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe)
  );

  cds_seq_datapath #(
    .HIT_DELAY_CYC(HIT_DELAY_CYC),
    .CAP_W        (3)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .hitIn          (hitIn),
    .cfgWrite       (cfgWrite),
    .cfgPolarity    (cfgPolarity),
    .cfgCapSel      (cfgCapSel),
    .intReset       (intReset),
    .discReset      (discReset),
    .thresholdInject(thresholdInject),
    .chargeInject   (chargeInject),
    .sample1        (sample1),
    .sample2        (sample2),
    .muxSelect      (muxSelect),
    .busy           (busy),
    .hitOut         (hitOut),
    .polarityInvert (polarityInvert),
    .capSel         (capSel),
    .capWeight      (capWeight)
  );

endmodule

// File: rtl/cds_seq_checker.sv
module cds_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       intReset,
  input logic       discReset,
  input logic       thresholdInject,
  input logic       chargeInject,
  input logic       sample1,
  input logic       sample2,
  input logic       muxSelect,
  input logic       busy,
  input logic       hitOut,
  input logic       polarityInvert,
  input logic [2:0] capSel
);

  p_exclusive_phases_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intReset, thresholdInject, sample1, chargeInject, sample2, muxSelect}));

  p_cycle_opens_with_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (intReset && discReset));

  p_sample1_on_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    sample1 |-> (!discReset && $past(discReset)));

  p_sample2_after_settle_r4: assert property (@(posedge clk) disable iff (!rstN)
    sample2 |-> (!chargeInject && $past(chargeInject)));

  p_hit_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |=> !hitOut);

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(capSel) && $stable(polarityInvert)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(intReset || discReset || thresholdInject || sample1 ||
                chargeInject || sample2 || muxSelect));

endmodule

bind cds_sequencer cds_seq_checker u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .intReset       (intReset),
  .discReset      (discReset),
  .thresholdInject(thresholdInject),
  .chargeInject   (chargeInject),
  .sample1        (sample1),
  .sample2        (sample2),
  .muxSelect      (muxSelect),
  .busy           (busy),
  .hitOut         (hitOut),
  .polarityInvert (polarityInvert),
  .capSel         (capSel)
);

// File: tb/cds_sequencer_tb.sv
`timescale 1ns/1ps
module cds_sequencer_tb;

  localparam int INTRST = 3, SETTLE1 = 5, THRESH = 2, INJECT = 3, SETTLE2 = 4, READ = 3;
  localparam int HDLY = 4;
  localparam int S1E = (SETTLE1 > SETTLE2) ? SETTLE1 : SETTLE2 + 1;
  // Slot boundaries (slot 1 = first cycle after the edge following start)
  localparam int B_INT = INTRST;
  localparam int B_S1  = B_INT + S1E;
  localparam int B_TH  = B_S1 + THRESH;
  localparam int B_SP1 = B_TH + 1;
  localparam int B_S2  = B_SP1 + INJECT + SETTLE2;
  localparam int B_SP2 = B_S2 + 1;
  localparam int B_RD  = B_SP2 + READ;
  localparam int TRACE = B_RD + 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, hitIn = 1'b0, cfgWrite = 1'b0, cfgPolarity = 1'b0;
  logic [2:0] cfgCapSel = 3'b000;

  logic intReset, discReset, thresholdInject, chargeInject, sample1, sample2, muxSelect, busy, hitOut;
  logic polarityInvert;
  logic [2:0] capSel, capWeight;

  logic cIntReset, cDiscReset, cThresh, cInject, cSample1, cSample2, cMux, cBusy, cHitOut, cPol;
  logic [2:0] cCapSel, cCapWeight;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cds_sequencer #(
    .INTRST_CYC(INTRST), .SETTLE1_CYC(SETTLE1), .THRESH_CYC(THRESH),
    .INJECT_CYC(INJECT), .SETTLE2_CYC(SETTLE2), .READ_CYC(READ), .HIT_DELAY_CYC(HDLY)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .hitIn(hitIn), .cfgWrite(cfgWrite),
    .cfgPolarity(cfgPolarity), .cfgCapSel(cfgCapSel),
    .intReset(intReset), .discReset(discReset), .thresholdInject(thresholdInject),
    .chargeInject(chargeInject), .sample1(sample1), .sample2(sample2), .muxSelect(muxSelect),
    .busy(busy), .hitOut(hitOut), .polarityInvert(polarityInvert), .capSel(capSel),
    .capWeight(capWeight)
  );

  // First settle programmed shorter than the second: must be stretched to 5
  cds_sequencer #(
    .INTRST_CYC(INTRST), .SETTLE1_CYC(2), .THRESH_CYC(THRESH),
    .INJECT_CYC(INJECT), .SETTLE2_CYC(SETTLE2), .READ_CYC(READ), .HIT_DELAY_CYC(HDLY)
  ) u_clamp (
    .clk(clk), .rstN(rstN), .start(start), .hitIn(hitIn), .cfgWrite(cfgWrite),
    .cfgPolarity(cfgPolarity), .cfgCapSel(cfgCapSel),
    .intReset(cIntReset), .discReset(cDiscReset), .thresholdInject(cThresh),
    .chargeInject(cInject), .sample1(cSample1), .sample2(cSample2), .muxSelect(cMux),
    .busy(cBusy), .hitOut(cHitOut), .polarityInvert(cPol), .capSel(cCapSel),
    .capWeight(cCapWeight)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {intReset, discReset, thresholdInject, sample1, chargeInject, sample2, muxSelect, busy}
  function automatic logic [7:0] expPins(input int i);
    logic [7:0] v;
    v[7] = (i >= 1) && (i <= B_INT);
    v[6] = (i >= 1) && (i <= B_TH);
    v[5] = (i > B_S1) && (i <= B_TH);
    v[4] = (i == B_SP1);
    v[3] = (i > B_SP1) && (i <= B_S2);
    v[2] = (i == B_SP2);
    v[1] = (i > B_SP2) && (i <= B_RD);
    v[0] = (i >= 1) && (i <= B_RD);
    return v;
  endfunction

  // Runs one cycle; inputs for slot i are driven during slot i (seen at the next edge)
  task automatic runCycle(input string tag, input int h1, input int h2, input int expHit,
                          input int restartAt, input int cfgAt);
    logic [7:0] mainPins, clampPins, exp;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 1; i <= TRACE; i++) begin
      @(negedge clk);
      exp       = expPins(i);
      mainPins  = {intReset, discReset, thresholdInject, sample1, chargeInject, sample2, muxSelect, busy};
      clampPins = {cIntReset, cDiscReset, cThresh, cSample1, cInject, cSample2, cMux, cBusy};
      check(mainPins == exp, {tag, " R2 R3 R4 R11"}, $sformatf("pins slot %0d", i), 32'(mainPins), 32'(exp));
      check(clampPins == exp, "R5", $sformatf("clamped pins slot %0d", i), 32'(clampPins), 32'(exp));
      check(hitOut == (i == expHit), tag, $sformatf("hitOut slot %0d", i), 32'(hitOut), 32'(i == expHit));
      hitIn       = (i == h1) || (i == h2);
      start       = (i == restartAt);
      cfgWrite    = (i == cfgAt);
      cfgPolarity = 1'b1;
      cfgCapSel   = 3'b000;
    end
    hitIn = 1'b0; start = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check({intReset, discReset, thresholdInject, chargeInject, sample1, sample2, muxSelect} == 7'b0,
          "R1", "strobes after reset", 32'({intReset, discReset, thresholdInject, chargeInject,
          sample1, sample2, muxSelect}), 0);
    check(busy == 1'b0 && hitOut == 1'b0, "R1", "busy/hitOut after reset", 32'({busy, hitOut}), 0);
    check(polarityInvert == 1'b0, "R1", "polarity after reset", 32'(polarityInvert), 0);
    check(capSel == 3'b111, "R1", "capSel after reset", 32'(capSel), 32'h7);
    check(capWeight == 3'd0, "R9", "weight for code 111", 32'(capWeight), 0);
  endtask

  task automatic test_plain();
    runCycle("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic test_hit_in_window();
    // accepted at slot 13 edge, second hit at 15 ignored
    runCycle("R6", B_SP1 + 2, B_SP1 + 4, B_SP1 + 2 + 1 + HDLY, 0, 0);
  endtask

  task automatic test_hit_last_slot();
    // last window slot; pulse lands after busy falls
    runCycle("R6", B_S2, 0, B_S2 + 1 + HDLY, 0, 0);
  endtask

  task automatic test_hit_outside();
    runCycle("R7", B_SP1, B_SP2, 0, 0, 0);
    runCycle("R7", B_RD + 2, B_TH, 0, 0, 0);
  endtask

  task automatic test_restart();
    runCycle("R10", 0, 0, 0, 5, 0);
    runCycle("R10", 0, 0, 0, B_RD - 1, 0);
  endtask

  task automatic test_config();
    runCycle("R8", 0, 0, 0, 0, 6);
    check(capSel == 3'b111, "R8", "capSel after busy write", 32'(capSel), 32'h7);
    check(polarityInvert == 1'b0, "R8", "polarity after busy write", 32'(polarityInvert), 0);
    @(negedge clk) begin cfgWrite = 1'b1; cfgPolarity = 1'b1; cfgCapSel = 3'b000; end
    @(negedge clk) cfgWrite = 1'b0;
    check(capSel == 3'b000, "R8", "capSel after idle write", 32'(capSel), 0);
    check(polarityInvert == 1'b1, "R8", "polarity after idle write", 32'(polarityInvert), 1);
    check(capWeight == 3'd7, "R9", "weight for code 000", 32'(capWeight), 7);
    @(negedge clk) begin cfgWrite = 1'b1; cfgPolarity = 1'b0; cfgCapSel = 3'b010; end
    @(negedge clk) cfgWrite = 1'b0;
    check(capWeight == 3'd5, "R9", "weight for code 010", 32'(capWeight), 5);
    check(polarityInvert == 1'b0, "R8", "polarity back to non-inverting", 32'(polarityInvert), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_plain();
    test_hit_in_window();
    test_hit_last_slot();
    test_hit_outside();
    test_restart();
    test_config();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule